// File: doc/BRIEF.md
# Infrared Run-Length Pulse Sampler

This block watches one consumer-infrared receiver line and turns its waveform into a stream of run-length bytes. A free-running prescaler takes one sample of the line every `PRESCALE` core clocks. An optional inversion makes an active-low receiver look active-high. Each stretch of constant level becomes one byte: the top bit holds the level and the low seven bits hold the length in samples minus one. Short excursions are filtered out by a programmable noise threshold, and a long stretch of space closes the packet.

The byte goes out on a single-cycle write strobe to a receive FIFO that sits downstream. No backpressure is taken. If the FIFO is full it records the lost byte as an overflow. A one-cycle packet-end strobe comes out together with the final space code of each packet. Once a packet has ended, the sampler waits for the next pulse before it produces any more codes. Protocol decoding, carrier demodulation, buffering and the register interface are handled elsewhere.

Top module: `ir_run_sampler`

## Requirements
- R1: While enabled, the block takes one sample every `PRESCALE` (default 64) clocks. The first sample falls on the `PRESCALE`-th rising edge after the enable, so a run of N samples lasts N*`PRESCALE` clocks.
- R2: When `invert` is 1, the line is complemented before sampling, so a low `ir_in` counts as pulse.
- R3: Each code is 8 bits. Bit 7 is the run level (1 for pulse, 0 for space). Bits 6:0 hold the run length in samples minus one.
- R4: An excursion to the opposite level that lasts no more than `noise_thr` samples is merged into the surrounding run, and its samples are added to that run's length. A level change is accepted on the sample on which the new level exceeds `noise_thr` samples. The previous run's code is written on that sample.
- R5: When a space run reaches `idle_thr` samples, the block writes the code {0, `idle_thr`-1} and raises `pkt_end` for exactly one cycle, in the same cycle as that write.
- R6: A run longer than 128 samples is written as consecutive codes of the same level. Each full piece carries bits 6:0 = 127, and the rest carries the remainder minus one. The pieces are written 128 samples apart.
- R7: After a packet end, no code is produced until a pulse-level sample arrives. The first run of the new packet starts with that sample.
- R8: While `glb_en` or `rx_en` is 0, no code or `pkt_end` is produced. Clearing either one discards the pending run, resets the prescaler and returns to the waiting-for-pulse state.
- R9: After reset, `code_wr`, `code_data` and `pkt_end` are 0. Each code appears as a `code_wr` pulse one cycle long. No downstream signal gates it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| glb_en | input | 1 | Global block enable |
| rx_en | input | 1 | Receive path enable |
| invert | input | 1 | Complement the line before sampling |
| noise_thr | input | 6 | Longest excursion, in samples, that is treated as noise |
| idle_thr | input | 8 | Space length, in samples, that ends a packet |
| ir_in | input | 1 | Receiver line, synchronous to clk |
| code_wr | output | 1 | One-cycle write strobe for code_data |
| code_data | output | 8 | Run code: level in bit 7, length minus one in bits 6:0 |
| pkt_end | output | 1 | One-cycle packet-end strobe |

## Verification
The assertions assume the following about the inputs:
- `ir_in` is already synchronous to `clk`.
- The thresholds stay constant while a packet is in progress.
- `idle_thr` lies between `noise_thr`+2 and 128, so a packet end never coincides with a level change or a 128-sample split.

The stimulus respects these limits:
- It changes `ir_in` only on falling clock edges, in whole sample periods.
- It reprograms the thresholds only while the sampler is waiting for a pulse.
- It uses `noise_thr` values of 0 to 3 with `idle_thr` at 20 or 40.

// File: rtl/ir_run_sampler.sv
module ir_run_sampler #(
  parameter int PRESCALE = 64,
  parameter int NOISE_W  = 6,
  parameter int IDLE_W   = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               glb_en,
  input  logic               rx_en,
  input  logic               invert,
  input  logic [NOISE_W-1:0] noise_thr,
  input  logic [IDLE_W-1:0]  idle_thr,
  input  logic               ir_in,
  output logic               code_wr,
  output logic [7:0]         code_data,
  output logic               pkt_end
);
  localparam int PRE_W  = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam int LEN_W  = 7;
  localparam int RUN_W  = LEN_W + 1;
  localparam int TOT_W  = RUN_W + 1;
  localparam int ALT_W  = NOISE_W + 1;
  localparam int MAXRUN = 2 ** LEN_W;

  logic [PRE_W-1:0] pre;
  logic             active, lvl;
  logic [RUN_W-1:0] run_len;
  logic [ALT_W-1:0] alt;

  logic             run_on, tick, smp, confirm, idle_hit, over;
  logic [ALT_W-1:0] alt_nx;
  logic [TOT_W-1:0] tot;
  logic [LEN_W-1:0] tot_len;

  assign run_on   = glb_en & rx_en;
  assign tick     = run_on && (pre == PRE_W'(PRESCALE - 1));
  assign smp      = ir_in ^ invert;
  assign alt_nx   = alt + ALT_W'(1);
  assign confirm  = alt_nx > ALT_W'(noise_thr);
  assign tot      = TOT_W'(run_len) + TOT_W'(alt) + TOT_W'(1);
  assign over     = tot > TOT_W'(MAXRUN);
  assign idle_hit = !lvl && (tot >= TOT_W'(idle_thr));
  assign tot_len  = over ? LEN_W'(MAXRUN - 1) : LEN_W'(tot - TOT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre       <= '0;
      active    <= 1'b0;
      lvl       <= 1'b0;
      run_len   <= '0;
      alt       <= '0;
      code_wr   <= 1'b0;
      code_data <= '0;
      pkt_end   <= 1'b0;
    end else begin
      code_wr <= 1'b0;
      pkt_end <= 1'b0;
      if (!run_on) begin
        pre     <= '0;
        active  <= 1'b0;
        lvl     <= 1'b0;
        run_len <= '0;
        alt     <= '0;
      end else begin
        pre <= tick ? '0 : pre + PRE_W'(1);
        if (tick) begin
          if (!active) begin
            if (smp) begin
              active  <= 1'b1;
              lvl     <= 1'b1;
              run_len <= RUN_W'(1);
              alt     <= '0;
            end
          end else if (smp == lvl) begin
            alt <= '0;
            if (idle_hit) begin
              code_wr   <= 1'b1;
              code_data <= {1'b0, tot_len};
              pkt_end   <= 1'b1;
              active    <= 1'b0;
              run_len   <= '0;
            end else if (over) begin
              code_wr   <= 1'b1;
              code_data <= {lvl, tot_len};
              run_len   <= RUN_W'(tot - TOT_W'(MAXRUN));
            end else begin
              run_len <= RUN_W'(tot);
            end
          end else if (confirm) begin
            code_wr   <= 1'b1;
            code_data <= {lvl, LEN_W'(run_len - RUN_W'(1))};
            lvl       <= smp;
            run_len   <= RUN_W'(alt_nx);
            alt       <= '0;
          end else begin
            alt <= alt_nx;
          end
        end
      end
    end
  end
endmodule

// File: rtl/ir_run_sampler_chk.sv
module ir_run_sampler_chk (
  input logic clk,
  input logic rst_n,
  input logic glb_en,
  input logic rx_en,
  input logic code_wr,
  input logic code_lvl,
  input logic pkt_end
);
  logic ended;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                ended <= 1'b0;
    else if (pkt_end)          ended <= 1'b1;
    else if (code_wr)          ended <= 1'b0;
  end

  AST_END_WITH_SPACE_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_end |-> (code_wr && !code_lvl)); // R5
  AST_END_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_end |=> !pkt_end); // R5
  AST_GATED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !(glb_en && rx_en) |=> (!code_wr && !pkt_end)); // R8
  AST_WR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    code_wr |=> !code_wr); // R9
  AST_RESTART_ON_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (ended && code_wr && !pkt_end) |-> code_lvl); // R7
endmodule

bind ir_run_sampler ir_run_sampler_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .glb_en   (glb_en),
  .rx_en    (rx_en),
  .code_wr  (code_wr),
  .code_lvl (code_data[7]),
  .pkt_end  (pkt_end)
);

// File: tb/ir_run_sampler_test.sv
`timescale 1ns/1ps
module ir_run_sampler_test;
  localparam int PRE = 64;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rst_n, glb_en, rx_en, invert, ir_in;
  logic [5:0] noise_thr;
  logic [7:0] idle_thr;
  logic       code_wr, pkt_end;
  logic [7:0] code_data;

  ir_run_sampler uut (
    .clk(clk), .rst_n(rst_n), .glb_en(glb_en), .rx_en(rx_en), .invert(invert),
    .noise_thr(noise_thr), .idle_thr(idle_thr), .ir_in(ir_in),
    .code_wr(code_wr), .code_data(code_data), .pkt_end(pkt_end)
  );

  int n_chk = 0, n_bad = 0, cyc = 0, n_end = 0;
  bit finished = 0;
  logic [7:0] got[$];
  int got_cyc[$];

  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) if (rst_n) begin
    if (code_wr) begin got.push_back(code_data); got_cyc.push_back(cyc); end
    if (pkt_end) n_end++;
  end

  typedef struct packed {
    logic [5:0] nz;
    logic [7:0] p, g, p2;
    logic [2:0] n;
    logic [7:0] c0, c1, c2, c3;
  } vec_t;

  localparam vec_t VEC [5] = '{
    '{nz: 6'd1, p: 8'd10, g: 8'd8, p2: 8'd5, n: 3'd4, c0: 8'h89, c1: 8'h07, c2: 8'h84, c3: 8'h13},
    '{nz: 6'd1, p: 8'd10, g: 8'd1, p2: 8'd5, n: 3'd2, c0: 8'h8F, c1: 8'h13, c2: 8'h00, c3: 8'h00},
    '{nz: 6'd0, p: 8'd3,  g: 8'd1, p2: 8'd2, n: 3'd4, c0: 8'h82, c1: 8'h00, c2: 8'h81, c3: 8'h13},
    '{nz: 6'd3, p: 8'd6,  g: 8'd3, p2: 8'd4, n: 3'd2, c0: 8'h8C, c1: 8'h13, c2: 8'h00, c3: 8'h00},
    '{nz: 6'd3, p: 8'd6,  g: 8'd4, p2: 8'd4, n: 3'd4, c0: 8'h85, c1: 8'h03, c2: 8'h83, c3: 8'h13}
  };

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic smp(input logic v, input int n);
    for (int i = 0; i < n; i++) begin
      ir_in = v;
      repeat (PRE) @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic clr();
    got.delete(); got_cyc.delete(); n_end = 0;
  endtask

  task automatic check_code(input string tag, input int k, input logic [7:0] exp);
    check(tag, (k < got.size()) ? int'(got[k]) : -1, int'(exp));
  endtask

  initial begin
    #(4 * 200000);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual running expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 0; glb_en = 0; rx_en = 0; invert = 0; ir_in = 0;
    noise_thr = 6'd1; idle_thr = 8'd20;
    repeat (3) @(negedge clk);
    check("R9 reset code_wr", int'(code_wr), 0);
    check("R9 reset code_data", int'(code_data), 0);
    check("R9 reset pkt_end", int'(pkt_end), 0);
    rst_n = 1;
    @(negedge clk);
    glb_en = 1; rx_en = 1;

    for (int i = 0; i < 5; i++) begin
      logic [7:0] exp [4];
      exp = '{VEC[i].c0, VEC[i].c1, VEC[i].c2, VEC[i].c3};
      noise_thr = VEC[i].nz;
      clr();
      smp(1'b1, int'(VEC[i].p));
      smp(1'b0, int'(VEC[i].g));
      smp(1'b1, int'(VEC[i].p2));
      smp(1'b0, 24);
      check($sformatf("R4 vec%0d code count", i), got.size(), int'(VEC[i].n));
      for (int k = 0; k < int'(VEC[i].n); k++)
        check_code($sformatf("R3 vec%0d code%0d", i, k), k, exp[k]);
      check($sformatf("R5 vec%0d pkt_end count", i), n_end, 1);
    end

    clr();
    smp(1'b0, 10);
    check("R7 silent after packet end", got.size(), 0);

    noise_thr = 6'd0;
    clr();
    smp(1'b1, 300);
    smp(1'b0, 24);
    check("R6 split count", got.size(), 4);
    check_code("R6 split piece0", 0, 8'hFF);
    check_code("R6 split piece1", 1, 8'hFF);
    check_code("R6 split rest", 2, 8'hAB);
    check_code("R5 split tail idle", 3, 8'h13);
    check("R1 split spacing", (got_cyc.size() > 1) ? got_cyc[1] - got_cyc[0] : -1, 128 * PRE);

    idle_thr = 8'd40;
    clr();
    smp(1'b1, 2);
    smp(1'b0, 45);
    check_code("R5 idle40 pulse", 0, 8'h81);
    check_code("R5 idle40 space", 1, 8'h27);
    check("R5 idle40 count", got.size(), 2);
    check("R5 idle40 pkt_end", n_end, 1);
    idle_thr = 8'd20;

    clr();
    smp(1'b1, 6);
    rx_en = 0;
    repeat (100) @(negedge clk);
    check("R8 nothing while disabled", got.size(), 0);
    rx_en = 1;
    smp(1'b0, 3);
    check("R8 restart waits for pulse", got.size(), 0);
    smp(1'b1, 4);
    smp(1'b0, 24);
    check_code("R8 fresh run after rx_en", 0, 8'h83);
    check_code("R8 fresh idle after rx_en", 1, 8'h13);
    check("R8 code count after rx_en", got.size(), 2);

    clr();
    smp(1'b1, 5);
    glb_en = 0;
    repeat (10) @(negedge clk);
    glb_en = 1;
    smp(1'b0, 30);
    check("R8 glb_en drops pending run", got.size(), 0);
    check("R8 glb_en no pkt_end", n_end, 0);

    invert = 1;
    clr();
    smp(1'b0, 7);
    smp(1'b1, 24);
    check_code("R2 inverted pulse", 0, 8'h86);
    check_code("R2 inverted idle", 1, 8'h13);
    check("R2 inverted count", got.size(), 2);
    invert = 0;

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule